// File: doc/BRIEF.md
# Receiver control line sequencer

This block drives the eight control lines of a paging receiver front end. A host writes a set of small configuration packets through a write port that carries an ID byte and a data word. Four setting packets define the warm-up states. Each state has a line pattern, a dwell time counted in 625 µs timebase ticks, a setting number and a low-battery sample flag. A separate force packet lets the host pin any single line to a chosen level.

When decoding is enabled, the sequencer walks through the four states in order. It drives each state's pattern for that state's dwell time. If a state has its low-battery flag set, the sequencer samples the low-battery input as it leaves the state. After the last state it raises a warm-up-done flag and holds the final pattern until decoding is disabled. Forced lines override the sequencer one line at a time. While reset is asserted the lines are released to high impedance.

Top module: `rx_line_sequencer`

## Requirements
- R1: While rst_ni is low, line_oe_o is 0 and every other output is 0. From the first clock edge after reset is released, line_oe_o is 1.
- R2: A packet with ID 0Fh loads the force settings. For line k, data bit 2k+1 is the force enable and data bit 2k is the forced level. The value takes effect at the clock edge that accepts the packet. While the force enable of line k is 1, line_o[k] equals that line's forced level.
- R3: While the force enable of line k is 0, line_o[k] follows the sequencer pattern. All force enables and levels are 0 after reset.
- R4: A packet with ID 16h+n (n = 0..3) writes state slot n. The data fields are: bits 19:16 setting number, bit 15 low-battery sample flag, bits 14:8 step time, bits 7:0 line pattern.
- R5: When decode_en_i is sampled high while the sequencer is idle, it enters slot 0 at that edge. line_o then shows slot 0's pattern (forced lines excepted) and setting_o shows slot 0's setting number.
- R6: A state lasts exactly as many tick_i pulses as its step time. The state advances at the edge that samples the final pulse. Slots are visited in the order 0, 1, 2, 3.
- R7: At the edge that samples the final tick of slot 3, warm_done_o rises. warm_done_o, the slot 3 pattern and the slot 3 setting number then hold while decode_en_i stays high, whatever tick_i does.
- R8: When decode_en_i is sampled low, at that edge the sequencer returns to idle: pattern 0, setting_o 0, warm_done_o 0. This also aborts a sequence in progress.
- R9: On leaving a state whose sample flag is set, lowbat_o takes the value of lowbat_i at the exiting edge. lowbat_o changes at no other time.
- R10: A step time of 0 behaves as a step time of 1.
- R11: Packets with any ID other than 0Fh and 16h..19h change no output and no stored setting.
- R12: A setting packet written to a slot takes effect the next time the sequencer enters that slot. The state currently being driven keeps its entry values.
- R13: After reset every slot has step time 1, pattern 0, setting number 0 and the sample flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Packet write strobe, one cycle per packet |
| pkt_id_i | input | 8 | Packet ID |
| pkt_data_i | input | 20 | Packet data |
| decode_en_i | input | 1 | Decoding enabled; starts the warm-up sequence |
| lowbat_i | input | 1 | Low-battery detector input |
| tick_i | input | 1 | Single-cycle 625 µs timebase pulse |
| line_o | output | 8 | Receiver control line levels |
| line_oe_o | output | 1 | Output enable for the control lines (0 = high impedance) |
| setting_o | output | 4 | Setting number of the active state, 0 when idle |
| lowbat_o | output | 1 | Latched low-battery status |
| warm_done_o | output | 1 | Warm-up sequence complete |

## Verification
The hardest situation to reach is a setting packet that arrives in the middle of a running state. The rewritten slot must leave the current line pattern and dwell time alone, yet be used on the next entry. Together with this, the low-battery sample must land exactly on the exit edge of a flagged state. The stimulus interleaves random setting, force and unknown-ID packets and idle cycles between individual tick pulses of each dwell. A directed run rewrites the active slot and the next slot during the first dwell. The bench keeps its own per-slot table and captures a slot's values only at the moment it predicts that slot's entry.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam int NUM_LINES = 8;
  localparam int NUM_SLOTS = 4;
  localparam int STEP_W    = 7;
  localparam int SETNUM_W  = 4;
  localparam int ID_W      = 8;

  // setting packet layout
  localparam int PAT_LSB   = 0;
  localparam int STEP_LSB  = PAT_LSB + NUM_LINES;
  localparam int LBC_BIT   = STEP_LSB + STEP_W;
  localparam int SET_LSB   = LBC_BIT + 1;
  localparam int PKT_W     = SET_LSB + SETNUM_W;

  localparam int IDX_W     = $clog2(NUM_SLOTS);

  typedef struct packed {
    logic [SETNUM_W-1:0]  setnum;
    logic                 lbc;
    logic [STEP_W-1:0]    step;
    logic [NUM_LINES-1:0] pat;
  } slot_cfg_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rls_cfg_bank.sv
module rls_cfg_bank
  import rls_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_FORCE     = 8'h0F,
  parameter logic [ID_W-1:0] ID_SLOT_BASE = 8'h16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ID_W-1:0]      id_i,
  input  logic [PKT_W-1:0]     data_i,
  output slot_cfg_t            slot_o [NUM_SLOTS],
  output logic [NUM_LINES-1:0] force_en_o,
  output logic [NUM_LINES-1:0] force_lvl_o
);

  localparam slot_cfg_t SLOT_RST = '{setnum: '0, lbc: 1'b0,
                                     step: STEP_W'(1), pat: '0};

  slot_cfg_t pkt_slot;
  assign pkt_slot.setnum = data_i[SET_LSB +: SETNUM_W];
  assign pkt_slot.lbc    = data_i[LBC_BIT];
  assign pkt_slot.step   = data_i[STEP_LSB +: STEP_W];
  assign pkt_slot.pat    = data_i[PAT_LSB +: NUM_LINES];

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    logic hit;
    assign hit = wr_i && (id_i == ID_W'(ID_SLOT_BASE + n));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  slot_o[n] <= SLOT_RST;
      else if (hit) slot_o[n] <= pkt_slot;
    end
  end

  logic force_hit;
  assign force_hit = wr_i && (id_i == ID_FORCE);

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_force
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        force_en_o[k]  <= 1'b0;
        force_lvl_o[k] <= 1'b0;
      end else if (force_hit) begin
        force_en_o[k]  <= data_i[2*k+1];
        force_lvl_o[k] <= data_i[2*k];
      end
    end
  end

endmodule

// File: rtl/rls_step_timer.sv
module rls_step_timer #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expire_o,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= (load_val_i == '0) ? W'(1) : load_val_i;
    else if (tick_i && cnt_q > W'(1)) cnt_q <= cnt_q - W'(1);
  end

  assign expire_o = tick_i && (cnt_q == W'(1));
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/rls_seq_ctrl.sv
module rls_seq_ctrl
  import rls_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 decode_en_i,
  input  logic                 lowbat_i,
  input  logic                 expire_i,
  input  slot_cfg_t            slot_i [NUM_SLOTS],
  output logic                 load_o,
  output logic [STEP_W-1:0]    load_val_o,
  output logic                 run_o,
  output logic [NUM_LINES-1:0] pat_o,
  output logic [SETNUM_W-1:0]  setnum_o,
  output logic                 done_o,
  output logic                 lowbat_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  slot_cfg_t        act_q;
  logic             lowbat_q;
  logic             start, advance, finish;

  assign idx_nxt = (idx_q == LAST) ? idx_q : idx_q + IDX_W'(1);
  assign start   = decode_en_i && (state_q == SEQ_IDLE);
  assign advance = decode_en_i && (state_q == SEQ_RUN) && expire_i && (idx_q != LAST);
  assign finish  = decode_en_i && (state_q == SEQ_RUN) && expire_i && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      idx_q    <= '0;
      act_q    <= '0;
      lowbat_q <= 1'b0;
    end else if (!decode_en_i) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      act_q   <= '0;
    end else begin
      if (start) begin
        state_q <= SEQ_RUN;
        idx_q   <= '0;
        act_q   <= slot_i[0];
      end
      if ((advance || finish) && act_q.lbc) lowbat_q <= lowbat_i;
      if (advance) begin
        idx_q <= idx_nxt;
        act_q <= slot_i[idx_nxt];
      end
      if (finish) state_q <= SEQ_DONE;
    end
  end

  assign load_o     = start || advance;
  assign load_val_o = start ? slot_i[0].step : slot_i[idx_nxt].step;
  assign run_o      = (state_q == SEQ_RUN);
  assign pat_o      = act_q.pat;
  assign setnum_o   = act_q.setnum;
  assign done_o     = (state_q == SEQ_DONE);
  assign lowbat_o   = lowbat_q;

endmodule

// File: rtl/rls_line_drive.sv
module rls_line_drive
  import rls_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] seq_pat_i,
  input  logic [NUM_LINES-1:0] force_en_i,
  input  logic [NUM_LINES-1:0] force_lvl_i,
  output logic [NUM_LINES-1:0] line_o,
  output logic                 line_oe_o
);

  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= 1'b1;
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign line_o[k] = force_en_i[k] ? force_lvl_i[k] : seq_pat_i[k];
  end

  assign line_oe_o = oe_q;

endmodule

// File: rtl/rx_line_sequencer.sv
module rx_line_sequencer
  import rls_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_FORCE     = 8'h0F,
  parameter logic [ID_W-1:0] ID_SLOT_BASE = 8'h16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pkt_valid_i,
  input  logic [ID_W-1:0]      pkt_id_i,
  input  logic [PKT_W-1:0]     pkt_data_i,
  input  logic                 decode_en_i,
  input  logic                 lowbat_i,
  input  logic                 tick_i,
  output logic [NUM_LINES-1:0] line_o,
  output logic                 line_oe_o,
  output logic [SETNUM_W-1:0]  setting_o,
  output logic                 lowbat_o,
  output logic                 warm_done_o
);

  slot_cfg_t            slot_cfg [NUM_SLOTS];
  logic [NUM_LINES-1:0] force_en, force_lvl, seq_pat;
  logic                 seq_run, tmr_load, tmr_expire;
  logic [STEP_W-1:0]    tmr_load_val, step_cnt;

  rls_cfg_bank #(
    .ID_FORCE    (ID_FORCE),
    .ID_SLOT_BASE(ID_SLOT_BASE)
  ) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (pkt_valid_i),
    .id_i       (pkt_id_i),
    .data_i     (pkt_data_i),
    .slot_o     (slot_cfg),
    .force_en_o (force_en),
    .force_lvl_o(force_lvl)
  );

  rls_step_timer #(.W(STEP_W)) i_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_load_val),
    .tick_i    (tick_i && seq_run),
    .expire_o  (tmr_expire),
    .cnt_o     (step_cnt)
  );

  rls_seq_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .decode_en_i(decode_en_i),
    .lowbat_i   (lowbat_i),
    .expire_i   (tmr_expire),
    .slot_i     (slot_cfg),
    .load_o     (tmr_load),
    .load_val_o (tmr_load_val),
    .run_o      (seq_run),
    .pat_o      (seq_pat),
    .setnum_o   (setting_o),
    .done_o     (warm_done_o),
    .lowbat_o   (lowbat_o)
  );

  rls_line_drive i_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seq_pat_i  (seq_pat),
    .force_en_i (force_en),
    .force_lvl_i(force_lvl),
    .line_o     (line_o),
    .line_oe_o  (line_oe_o)
  );

endmodule

// File: rtl/rls_checker.sv
module rls_checker
  import rls_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 decode_en_i,
  input logic                 tick_i,
  input logic [NUM_LINES-1:0] line_o,
  input logic                 line_oe_o,
  input logic [SETNUM_W-1:0]  setting_o,
  input logic                 lowbat_o,
  input logic                 warm_done_o,
  input logic [NUM_LINES-1:0] force_en,
  input logic [NUM_LINES-1:0] force_lvl,
  input logic [NUM_LINES-1:0] seq_pat,
  input logic                 seq_run,
  input logic [STEP_W-1:0]    step_cnt
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_hiz_in_reset_R1: assert (line_oe_o == 1'b0)
        else $error("lines driven during reset");
    end
  end

  assert_driven_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> line_oe_o);

  assert_forced_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((line_o ^ force_lvl) & force_en) == '0);

  assert_released_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((line_o ^ seq_pat) & ~force_en) == '0);

  assert_dwell_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_run |-> (step_cnt != '0));

  assert_done_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warm_done_o) |-> $past(tick_i && seq_run));

  assert_idle_on_disable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decode_en_i |=> (!warm_done_o && seq_pat == '0 && setting_o == '0));

  assert_lowbat_on_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lowbat_o) |-> $past(tick_i && seq_run));

endmodule

bind rx_line_sequencer rls_checker i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .decode_en_i(decode_en_i),
  .tick_i     (tick_i),
  .line_o     (line_o),
  .line_oe_o  (line_oe_o),
  .setting_o  (setting_o),
  .lowbat_o   (lowbat_o),
  .warm_done_o(warm_done_o),
  .force_en   (force_en),
  .force_lvl  (force_lvl),
  .seq_pat    (seq_pat),
  .seq_run    (seq_run),
  .step_cnt   (step_cnt)
);

// File: tb/test_rx_line_sequencer.sv
module test_rx_line_sequencer;
  import rls_pkg::*;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 pkt_valid_i = 1'b0;
  logic [ID_W-1:0]      pkt_id_i = '0;
  logic [PKT_W-1:0]     pkt_data_i = '0;
  logic                 decode_en_i = 1'b0;
  logic                 lowbat_i = 1'b0;
  logic                 tick_i = 1'b0;
  logic [NUM_LINES-1:0] line_o;
  logic                 line_oe_o;
  logic [SETNUM_W-1:0]  setting_o;
  logic                 lowbat_o;
  logic                 warm_done_o;

  always #2 clk = ~clk;

  rx_line_sequencer i_rx_line_sequencer (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pkt_valid_i(pkt_valid_i),
    .pkt_id_i   (pkt_id_i),
    .pkt_data_i (pkt_data_i),
    .decode_en_i(decode_en_i),
    .lowbat_i   (lowbat_i),
    .tick_i     (tick_i),
    .line_o     (line_o),
    .line_oe_o  (line_oe_o),
    .setting_o  (setting_o),
    .lowbat_o   (lowbat_o),
    .warm_done_o(warm_done_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model
  logic [NUM_LINES-1:0] m_pat [NUM_SLOTS];
  logic                 m_lbc [NUM_SLOTS];
  logic [STEP_W-1:0]    m_st  [NUM_SLOTS];
  logic [SETNUM_W-1:0]  m_set [NUM_SLOTS];
  logic [NUM_LINES-1:0] f_en, f_lvl, a_pat;
  logic [SETNUM_W-1:0]  a_set;
  logic                 a_done, e_lb, e_oe;

  function automatic logic [PKT_W-1:0] mk_set(logic [3:0] s, logic l, logic [6:0] st, logic [7:0] p);
    return {s, l, st, p};
  endfunction

  function automatic logic [15:0] mk_force(logic [7:0] en, logic [7:0] lv);
    logic [15:0] d;
    for (int k = 0; k < 8; k++) begin
      d[2*k+1] = en[k];
      d[2*k]   = lv[k];
    end
    return d;
  endfunction

  function automatic logic [7:0] exp_lines();
    return (f_en & f_lvl) | (~f_en & a_pat);
  endfunction

  function automatic int eff_st(logic [6:0] st);
    return (st == 0) ? 1 : int'(st);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req);
    logic [14:0] act, exp;
    act = {line_o, line_oe_o, setting_o, lowbat_o, warm_done_o};
    exp = {exp_lines(), e_oe, a_set, e_lb, a_done};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got line=%h oe=%b set=%h lb=%b done=%b, want line=%h oe=%b set=%h lb=%b done=%b",
               req, act[14:7], act[6], act[5:2], act[1], act[0],
               exp[14:7], exp[6], exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic write_pkt(logic [7:0] id, logic [PKT_W-1:0] d);
    pkt_valid_i = 1'b1;
    pkt_id_i    = id;
    pkt_data_i  = d;
    step();
    pkt_valid_i = 1'b0;
    if (id == 8'h0F) begin
      for (int k = 0; k < 8; k++) begin
        f_en[k]  = d[2*k+1];
        f_lvl[k] = d[2*k];
      end
    end else if (id >= 8'h16 && id <= 8'h19) begin
      m_set[id-8'h16] = d[19:16];
      m_lbc[id-8'h16] = d[15];
      m_st[id-8'h16]  = d[14:8];
      m_pat[id-8'h16] = d[7:0];
    end
  endtask

  task automatic rand_pkt();
    int r;
    logic [7:0] id;
    r = $urandom % 3;
    if (r == 0) begin
      write_pkt(8'h0F, PKT_W'(mk_force(8'($urandom), 8'($urandom))));
      check("R2/R3 force packet");
    end else if (r == 1) begin
      write_pkt(8'(8'h16 + $urandom % 4),
                mk_set(4'($urandom), 1'($urandom), 7'($urandom % 6), 8'($urandom)));
      check("R4/R12 setting written while active");
    end else begin
      do id = 8'($urandom); while (id == 8'h0F || (id >= 8'h16 && id <= 8'h19));
      write_pkt(id, PKT_W'($urandom));
      check("R11 unknown id ignored");
    end
  endtask

  task automatic run_seq(bit noise, bit rewrite);
    logic lb;
    decode_en_i = 1'b1;
    step();
    a_done = 1'b0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      int eff;
      logic lbc;
      a_pat = m_pat[k];
      a_set = m_set[k];
      lbc   = m_lbc[k];
      eff   = eff_st(m_st[k]);
      check("R5/R6/R9 state entry");
      if (rewrite && k == 0) begin
        write_pkt(8'h16, mk_set(4'hA, 1'b1, 7'd9, 8'h3C));
        write_pkt(8'h17, mk_set(4'h5, 1'b0, 7'd1, 8'hC3));
        check("R12 active state keeps entry values");
      end
      for (int t = 0; t < eff; t++) begin
        if (noise && ($urandom % 4 == 0)) rand_pkt();
        if ($urandom % 3 == 0) begin
          step();
          check("R6 no tick no advance");
        end
        lb = 1'($urandom);
        lowbat_i = lb;
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
        if (t < eff - 1) check("R6 dwell continues");
        else if (lbc) e_lb = lb;
      end
    end
    a_done = 1'b1;
    check("R7/R9 warm-up done");
    for (int i = 0; i < 3; i++) begin
      tick_i = 1'b1;
      lowbat_i = ~e_lb;
      step();
      tick_i = 1'b0;
      check("R7 done holds");
    end
    decode_en_i = 1'b0;
    step();
    a_pat = '0; a_set = '0; a_done = 1'b0;
    check("R8 idle after disable");
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h0BADF00D));
    for (int n = 0; n < NUM_SLOTS; n++) begin
      m_pat[n] = '0; m_lbc[n] = 1'b0; m_st[n] = 7'd1; m_set[n] = '0;
    end
    f_en = '0; f_lvl = '0; a_pat = '0; a_set = '0;
    a_done = 1'b0; e_lb = 1'b0; e_oe = 1'b0;

    repeat (3) @(negedge clk);
    check("R1 high impedance in reset");
    rst_ni = 1'b1;
    step();
    e_oe = 1'b1;
    check("R1 driven after reset");

    // defaults: one tick per state
    run_seq(1'b0, 1'b0);
    check("R13 default step one tick");

    // force then release
    write_pkt(8'h0F, PKT_W'(mk_force(8'hFF, 8'hA5)));
    check("R2 all lines forced");
    write_pkt(8'h0F, PKT_W'(mk_force(8'h0F, 8'h00)));
    check("R3 upper lines released");

    // directed slots: step 0, lbc, max step
    write_pkt(8'h16, mk_set(4'h7, 1'b1, 7'd0,   8'h81));
    write_pkt(8'h17, mk_set(4'h8, 1'b0, 7'd3,   8'h42));
    write_pkt(8'h18, mk_set(4'h9, 1'b1, 7'd2,   8'h24));
    write_pkt(8'h19, mk_set(4'h3, 1'b1, 7'h7F,  8'h18));
    check("R4 setting packets stored");
    run_seq(1'b0, 1'b0);

    // R10 via step 0 on slot 0 already; R12 directed rewrite
    write_pkt(8'h16, mk_set(4'h1, 1'b0, 7'd3, 8'h11));
    write_pkt(8'h19, mk_set(4'h4, 1'b1, 7'd2, 8'h99));
    run_seq(1'b0, 1'b1);

    // abort mid-state
    write_pkt(8'h16, mk_set(4'h2, 1'b0, 7'd5, 8'h66));
    decode_en_i = 1'b1;
    step();
    a_pat = m_pat[0]; a_set = m_set[0];
    check("R5 entry before abort");
    for (int t = 0; t < 2; t++) begin
      tick_i = 1'b1;
      step();
      tick_i = 1'b0;
    end
    check("R6 mid dwell");
    decode_en_i = 1'b0;
    step();
    a_pat = '0; a_set = '0;
    check("R8 abort");

    // random configurations with interleaved packets
    for (int r = 0; r < 20; r++) begin
      for (int n = 0; n < NUM_SLOTS; n++)
        write_pkt(8'(8'h16 + n),
                  mk_set(4'($urandom), 1'($urandom), 7'($urandom % 6), 8'($urandom)));
      run_seq(1'b1, r[0]);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule